// File: doc/BRIEF.md
# Indirect SMI Register Access Bridge

This block is the slave-side management logic of a switch device on an MDIO/SMI bus. It receives already-decoded bus read and write strobes carrying a 5-bit PHY address, a 5-bit register number and 16-bit write data. It maps them onto an internal register space that is addressed by a 5-bit device number and a 5-bit register number. The internal space is a simple memory, and every access to it takes a fixed number of cycles.

A 5-bit strap input selects how the block is addressed. With a zero strap the block claims every PHY address, and each bus access goes straight to the internal device/register pair that matches the bus PHY address and register number. With a nonzero strap the block answers only at that one PHY address, where it offers two registers. Register 0 is a command word with a busy flag, and register 1 is a data word. Software writes a command that names a device and a register, then polls until busy clears. Read results arrive in the data word, and writes take their value from it.

Top module: `smi_reg_bridge`

## Requirements
- R1: After reset the command readback (register 0) is 0x0000, the data register (register 1) is 0x0000, busy is clear and `smi_rvalid` is low.
- R2: With a nonzero strap, strobes whose PHY address differs from the strap produce no `smi_rvalid` and change no state.
- R3: In indirect mode a read strobe gives `smi_rvalid` one cycle later. Register 0 returns {busy, last accepted command bits 14:0}, register 1 returns the data register, and any other register returns 0x0000. Writes to registers other than 0 and 1 have no effect.
- R4: The command word 0x9800 | dev<<5 | reg (bit 15 go, bit 12 enable, bits 11:10 = 10 read, dev in bits 9:5, reg in bits 4:0) loads the internal word at (dev, reg) into the data register.
- R5: The command word 0x9400 | dev<<5 | reg (bits 11:10 = 01) stores the data register into the internal word at (dev, reg).
- R6: A command word that lacks bit 15 or bit 12 is ignored, and the command readback stays unchanged.
- R7: While busy is set, writes to the command register and to the data register are ignored.
- R8: An accepted command whose opcode bits 11:10 are 00 or 11 updates the command readback but leaves busy clear and performs no internal access.
- R9: Busy stays set for exactly ACC_LAT cycles after a command is accepted. Polls of register 0 that start right after the command therefore see busy set ACC_LAT times.
- R10: With a zero strap, a write at any PHY address p and register r stores the value into internal (p, r). A read returns internal (p, r) on `smi_rvalid`, ACC_LAT+1 cycles after the strobe.
- R11: With a zero strap, a strobe that arrives while an internal access is still in progress is dropped: it produces no `smi_rvalid` and no write.
- R12: Reading the data register has no side effect, so repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 5 | Strap address; zero selects direct mode |
| smi_wr | input | 1 | Decoded bus write strobe, one cycle |
| smi_rd | input | 1 | Decoded bus read strobe, one cycle |
| smi_phy | input | 5 | Bus PHY address |
| smi_reg | input | 5 | Bus register number |
| smi_wdata | input | 16 | Bus write data |
| smi_rvalid | output | 1 | Read data valid pulse |
| smi_rdata | output | 16 | Read data |

## Verification
The hardest situation to reach is a command or data-register write that lands inside the busy window. Software that follows the polling rule never issues one. The bench therefore writes a second command and then a data value in the two cycles right after an accepted write command. It then checks that the stored word, the command readback and the data register all reflect only the first command. Direct-mode drops are reached the same way: a read strobe is issued in the cycle right after a direct write.

// File: rtl/smi_bridge_pkg.sv
package smi_bridge_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int FLAT_W   = 2 * ADDR_W;
    localparam int GO_BIT   = 15;
    localparam int EN_BIT   = 12;
    localparam int OP_HI    = 11;
    localparam int OP_LO    = 10;
    localparam logic [ADDR_W-1:0] CMD_REG  = 5'd0;
    localparam logic [ADDR_W-1:0] DATA_REG = 5'd1;

    typedef enum logic [1:0] {
        OPC_NONE  = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_BAD   = 2'b11
    } opcode_e;
endpackage

// File: rtl/smi_addr_decode.sv
module smi_addr_decode
    import smi_bridge_pkg::*;
(
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic [ADDR_W-1:0] smi_phy,
    input  logic              smi_wr,
    input  logic              smi_rd,
    output logic              direct_mode,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic match;

    always_comb begin
        direct_mode = (strap_addr == '0);
        match       = direct_mode || (smi_phy == strap_addr);
        wr_hit      = smi_wr && match;
        rd_hit      = smi_rd && match;
    end
endmodule

// File: rtl/smi_regfile_model.sv
module smi_regfile_model
    import smi_bridge_pkg::*;
#(
    parameter int AW = FLAT_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/smi_access_ctrl.sv
module smi_access_ctrl
    import smi_bridge_pkg::*;
#(
    parameter int ACC_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              direct_mode,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regn,
    input  logic [DATA_W-1:0] wdata,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_we,
    output logic [FLAT_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int CNT_W = $clog2(ACC_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_LAT - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              is_wr;
        logic              direct;
        logic [FLAT_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] cmd;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t   st_q, st_d;
    logic    done;
    opcode_e opc;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        done        = st_q.busy && (st_q.cnt == '0);
        opc         = opcode_e'(wdata[OP_HI:OP_LO]);

        if (st_q.busy && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (done) begin
            st_d.busy = 1'b0;
            if (!st_q.is_wr) begin
                if (st_q.direct) begin
                    st_d.rvalid = 1'b1;
                    st_d.rdata  = mem_rdata;
                end else begin
                    st_d.data = mem_rdata;
                end
            end
        end

        if (direct_mode) begin
            if (!st_q.busy && (wr_stb || rd_stb)) begin
                st_d.busy   = 1'b1;
                st_d.cnt    = CNT_LOAD;
                st_d.is_wr  = wr_stb;
                st_d.direct = 1'b1;
                st_d.addr   = {phy, regn};
                if (wr_stb) begin
                    st_d.data = wdata;
                end
            end
        end else begin
            if (rd_stb) begin
                st_d.rvalid = 1'b1;
                case (regn)
                    CMD_REG:  st_d.rdata = {st_q.busy, st_q.cmd[DATA_W-2:0]};
                    DATA_REG: st_d.rdata = st_q.data;
                    default:  st_d.rdata = '0;
                endcase
            end
            if (wr_stb && !st_q.busy) begin
                if (regn == DATA_REG) begin
                    st_d.data = wdata;
                end else if (regn == CMD_REG && wdata[GO_BIT] && wdata[EN_BIT]) begin
                    st_d.cmd = wdata;
                    if (opc == OPC_READ || opc == OPC_WRITE) begin
                        st_d.busy   = 1'b1;
                        st_d.cnt    = CNT_LOAD;
                        st_d.is_wr  = (opc == OPC_WRITE);
                        st_d.direct = 1'b0;
                        st_d.addr   = wdata[FLAT_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvalid    = st_q.rvalid;
    assign rdata     = st_q.rdata;
    assign mem_we    = done && st_q.is_wr;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.data;

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> st_q.busy);

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> ($past(st_q.cnt) == '0));

    assert_cmd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && wr_stb && !direct_mode) |=> $stable(st_q.cmd));

    assert_wdata_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.is_wr) |=> $stable(st_q.data));

    assert_rvalid_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rvalid) |-> ($past(rd_stb) || $past(st_q.busy)));
endmodule

// File: rtl/smi_reg_bridge.sv
module smi_reg_bridge
    import smi_bridge_pkg::*;
#(
    parameter int ACC_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              smi_wr,
    input  logic              smi_rd,
    input  logic [ADDR_W-1:0] smi_phy,
    input  logic [ADDR_W-1:0] smi_reg,
    input  logic [DATA_W-1:0] smi_wdata,
    output logic              smi_rvalid,
    output logic [DATA_W-1:0] smi_rdata
);
    logic              direct_mode;
    logic              wr_hit;
    logic              rd_hit;
    logic              mem_we;
    logic [FLAT_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    smi_addr_decode u_decode (
        .strap_addr (strap_addr),
        .smi_phy    (smi_phy),
        .smi_wr     (smi_wr),
        .smi_rd     (smi_rd),
        .direct_mode(direct_mode),
        .wr_hit     (wr_hit),
        .rd_hit     (rd_hit)
    );

    smi_access_ctrl #(.ACC_LAT(ACC_LAT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .direct_mode(direct_mode),
        .wr_stb     (wr_hit),
        .rd_stb     (rd_hit),
        .phy        (smi_phy),
        .regn       (smi_reg),
        .wdata      (smi_wdata),
        .rvalid     (smi_rvalid),
        .rdata      (smi_rdata),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    smi_regfile_model #(.AW(FLAT_W), .DW(DATA_W)) u_regs (
        .clk  (clk),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata(mem_wdata),
        .rdata(mem_rdata)
    );

    assert_no_stray_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_rd && !direct_mode && smi_phy != strap_addr && !smi_rvalid) |=> !smi_rvalid || $past(smi_rvalid));
endmodule

// File: tb/smi_reg_bridge_tb.sv
module smi_reg_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;
    localparam logic [4:0] STRAP = 5'd3;
    localparam int NVEC = 6;
    localparam logic [25:0] VEC [NVEC] = '{
        {5'd0,  5'd0,  16'h1111},
        {5'd31, 5'd31, 16'hFFFE},
        {5'd16, 5'd1,  16'hA5A5},
        {5'd1,  5'd16, 16'h5A5A},
        {5'd9,  5'd2,  16'h0001},
        {5'd27, 5'd11, 16'h8000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_addr = STRAP;
    logic        smi_wr = 1'b0;
    logic        smi_rd = 1'b0;
    logic [4:0]  smi_phy = '0;
    logic [4:0]  smi_reg = '0;
    logic [15:0] smi_wdata = '0;
    logic        smi_rvalid;
    logic [15:0] smi_rdata;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_reg_bridge #(.ACC_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
        .smi_wr(smi_wr), .smi_rd(smi_rd), .smi_phy(smi_phy), .smi_reg(smi_reg),
        .smi_wdata(smi_wdata), .smi_rvalid(smi_rvalid), .smi_rdata(smi_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        smi_wr = 1'b1; smi_phy = p; smi_reg = r; smi_wdata = d;
        @(negedge clk);
        smi_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] p, input logic [4:0] r,
                          output logic [15:0] d, output bit got, output int lat);
        smi_rd = 1'b1; smi_phy = p; smi_reg = r;
        @(negedge clk);
        smi_rd = 1'b0;
        got = 1'b0; d = '0; lat = 1;
        for (int i = 0; i < 30; i++) begin
            if (smi_rvalid) begin
                got = 1'b1; d = smi_rdata;
                break;
            end
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic poll_idle(output int busy_seen);
        logic [15:0] d; bit g; int l;
        busy_seen = 0;
        for (int i = 0; i < 40; i++) begin
            bus_rd(STRAP, 5'd0, d, g, l);
            if (!d[15]) break;
            busy_seen++;
        end
    endtask

    task automatic ind_write(input logic [4:0] dv, input logic [4:0] rg, input logic [15:0] v);
        int b;
        bus_wr(STRAP, 5'd1, v);
        bus_wr(STRAP, 5'd0, 16'h9400 | {6'd0, dv, rg});
        poll_idle(b);
    endtask

    task automatic ind_read(input logic [4:0] dv, input logic [4:0] rg, output logic [15:0] v);
        int b; bit g; int l;
        bus_wr(STRAP, 5'd0, 16'h9800 | {6'd0, dv, rg});
        poll_idle(b);
        bus_rd(STRAP, 5'd1, v, g, l);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        bit g;
        int l, b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rvalid idle", {31'd0, smi_rvalid}, 32'd0);
        bus_rd(STRAP, 5'd0, d, g, l);
        chk("R1 cmd readback", {15'd0, g, d}, {15'd0, 1'b1, 16'h0000});
        bus_rd(STRAP, 5'd1, d, g, l);
        chk("R1 data reg", {15'd0, g, d}, {15'd0, 1'b1, 16'h0000});

        // R2 foreign PHY address
        bus_rd(5'd4, 5'd0, d, g, l);
        chk("R2 no rvalid for other phy", {31'd0, g}, 32'd0);
        bus_wr(5'd4, 5'd1, 16'hBEEF);
        bus_rd(STRAP, 5'd1, d, g, l);
        chk("R2 data untouched", {16'd0, d}, 32'h0000);

        // R3 and R12 register map, latency, side-effect-free reads
        bus_wr(STRAP, 5'd1, 16'h1234);
        bus_rd(STRAP, 5'd1, d, g, l);
        chk("R3 read latency", l, 1);
        chk("R12 data first read", {16'd0, d}, 32'h1234);
        bus_rd(STRAP, 5'd1, d, g, l);
        chk("R12 data second read", {16'd0, d}, 32'h1234);
        bus_wr(STRAP, 5'd7, 16'h7777);
        bus_rd(STRAP, 5'd7, d, g, l);
        chk("R3 other reg reads zero", {16'd0, d}, 32'h0000);
        bus_rd(STRAP, 5'd1, d, g, l);
        chk("R3 other reg write no effect", {16'd0, d}, 32'h1234);

        // R4 R5 vector table: write then read back through commands
        for (int k = 0; k < NVEC; k++) begin
            ind_write(VEC[k][25:21], VEC[k][20:16], VEC[k][15:0]);
        end
        for (int k = 0; k < NVEC; k++) begin
            bus_wr(STRAP, 5'd1, 16'h0BAD);
            ind_read(VEC[k][25:21], VEC[k][20:16], d);
            chk("R4 R5 indirect round trip", {16'd0, d}, {16'd0, VEC[k][15:0]});
        end

        // R9 busy length seen by polls
        bus_wr(STRAP, 5'd0, 16'h9800 | {6'd0, VEC[0][25:16]});
        poll_idle(b);
        chk("R9 busy poll count", b, LAT);

        // R7 command and data writes during busy are ignored
        bus_wr(STRAP, 5'd1, 16'hC0DE);
        bus_wr(STRAP, 5'd0, 16'h9400 | {6'd0, VEC[1][25:16]});
        bus_wr(STRAP, 5'd0, 16'h9800 | {6'd0, VEC[2][25:16]});
        bus_wr(STRAP, 5'd1, 16'hDEAD);
        poll_idle(b);
        bus_rd(STRAP, 5'd0, d, g, l);
        chk("R7 cmd readback kept", {16'd0, d}, {16'd0, 16'h1400 | {6'd0, VEC[1][25:16]}});
        bus_rd(STRAP, 5'd1, d, g, l);
        chk("R7 data reg kept", {16'd0, d}, 32'hC0DE);
        ind_read(VEC[1][25:21], VEC[1][20:16], d);
        chk("R7 stored first command value", {16'd0, d}, 32'hC0DE);

        // R8 unknown opcodes
        bus_wr(STRAP, 5'd1, 16'hDEAD);
        bus_wr(STRAP, 5'd0, 16'h9C00 | {6'd0, VEC[0][25:16]});
        bus_rd(STRAP, 5'd0, d, g, l);
        chk("R8 op11 readback no busy", {16'd0, d}, {16'd0, 16'h1C00 | {6'd0, VEC[0][25:16]}});
        bus_wr(STRAP, 5'd0, 16'h9000 | {6'd0, VEC[0][25:16]});
        bus_rd(STRAP, 5'd0, d, g, l);
        chk("R8 op00 readback no busy", {16'd0, d}, {16'd0, 16'h1000 | {6'd0, VEC[0][25:16]}});
        ind_read(VEC[0][25:21], VEC[0][20:16], d);
        chk("R8 no internal write", {16'd0, d}, {16'd0, VEC[0][15:0]});

        // R6 missing go or enable bit
        bus_wr(STRAP, 5'd0, 16'h9C00);
        bus_wr(STRAP, 5'd0, 16'h1800 | 16'h0021);
        bus_rd(STRAP, 5'd0, d, g, l);
        chk("R6 no go bit ignored", {16'd0, d}, 32'h1C00);
        bus_wr(STRAP, 5'd0, 16'h8800 | 16'h0021);
        bus_rd(STRAP, 5'd0, d, g, l);
        chk("R6 no enable bit ignored", {16'd0, d}, 32'h1C00);

        // R10 direct mode
        strap_addr = 5'd0;
        @(negedge clk);
        bus_rd(VEC[2][25:21], VEC[2][20:16], d, g, l);
        chk("R10 direct read data", {16'd0, d}, {16'd0, VEC[2][15:0]});
        chk("R10 direct read latency", l, LAT + 1);
        bus_wr(5'd12, 5'd6, 16'h3C3C);
        repeat (LAT + 1) @(negedge clk);
        bus_rd(5'd12, 5'd6, d, g, l);
        chk("R10 direct write stored", {16'd0, d}, 32'h3C3C);

        // R11 strobe during direct access dropped
        bus_wr(5'd20, 5'd20, 16'h4242);
        bus_rd(5'd12, 5'd6, d, g, l);
        chk("R11 read dropped while busy", {31'd0, g}, 32'd0);
        bus_wr(5'd12, 5'd6, 16'h1111);
        bus_wr(5'd12, 5'd6, 16'h9999);
        repeat (LAT + 1) @(negedge clk);
        bus_rd(5'd12, 5'd6, d, g, l);
        chk("R11 second write dropped", {16'd0, d}, 32'h1111);
        bus_rd(5'd20, 5'd20, d, g, l);
        chk("R11 first write landed", {16'd0, d}, 32'h4242);

        // R10 cross-mode: direct write visible through indirect read
        strap_addr = STRAP;
        @(negedge clk);
        ind_read(5'd20, 5'd20, d);
        chk("R10 direct then indirect", {16'd0, d}, 32'h4242);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule